// File: doc/BRIEF.md
# Control-Transfer Target Capability Checker

This execute-stage block judges every jump and conditional branch before the program counter is redirected. It looks at the instruction class, whether the transfer is taken, the computed target and the decoded fields of the capability that will govern the target. It then decides whether the transfer may go ahead. If it may not, the block reports exactly one exception cause, chosen by a fixed priority, together with the target address. The fault is charged to the jump itself, not to the fetch at the target.

The bounds test adds a fixed byte slack to the target. The default slack of 2 only proves that a 16-bit instruction fits at the target. A slack of 4 proves that a full 32-bit instruction fits. Only transfers that are actually taken can fault. Checks that concern the capability itself apply only to register-indirect jumps, and they rank ahead of the representability and bounds tests.

Top module: `xfer_target_check`

## Requirements
- R1: A conditional branch (kind 2) with `taken` low raises nothing, even when its target is misaligned, out of bounds or unrepresentable.
- R2: A taken transfer whose target has bit 0 set, or, while `rvc_en` is low, has bit 1 set, reports cause 1 (misaligned).
- R3: A register-indirect jump (kind 1) whose capability tag is clear reports cause 2.
- R4: A register-indirect jump whose capability is sealed reports cause 3.
- R5: A register-indirect jump whose capability lacks execute permission reports cause 4.
- R6: A direct jump (kind 0) or a taken branch ignores the tag, sealed and execute inputs.
- R7: A taken transfer whose target is below `rep_base` or at or above `rep_top` reports cause 5 (representability).
- R8: A taken transfer whose target is below `cap_base`, or for which target plus `SLACK` exceeds `cap_top`, reports cause 6 (bounds). `SLACK` is 2 by default and may be set to 4.
- R9: When several checks fail, only the first in this order is reported: misaligned, tag, seal, permission, representability, bounds.
- R10: Results appear one clock after the input cycle and last one cycle. `exc_valid` is high exactly when `exc_cause` is non-zero, and `exc_addr` then equals the target. An invalid cycle, or kind 3, raises nothing. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A transfer instruction is presented this cycle |
| xfer_kind | input | 2 | 0 direct jump, 1 register-indirect jump, 2 conditional branch, 3 none |
| taken | input | 1 | Branch condition outcome (ignored for jumps) |
| target | input | ADDR_W | Computed target address |
| rvc_en | input | 1 | 16-bit instructions enabled (relaxes alignment to 2 bytes) |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability is sealed |
| cap_exec | input | 1 | Capability grants execute permission |
| cap_base | input | ADDR_W | Lower bound (inclusive) |
| cap_top | input | ADDR_W+1 | Upper bound (exclusive) |
| rep_base | input | ADDR_W | Lower limit of representable region (inclusive) |
| rep_top | input | ADDR_W+1 | Upper limit of representable region (exclusive) |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_cause | output | 3 | 0 none, 1 misaligned, 2 tag, 3 seal, 4 permission, 5 representability, 6 bounds |
| exc_addr | output | ADDR_W | Target address of the last presented transfer |

## Verification
The hardest situations to reach are the edges of the slack window and the case where several faults overlap. A target two bytes below the top passes with a slack of 2 but fails with a slack of 4. A target exactly at the top fails with either slack. The bench drives both slack settings side by side from the same stimulus, so one vector exposes the difference between them. For the priority order it stacks faults on a single register-indirect jump and removes them one at a time. Each step must reveal the next cause down the chain.

// File: rtl/xfer_target_check.sv
module xfer_target_check #(
  parameter int ADDR_W = 32,
  parameter int SLACK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [1:0]        xfer_kind,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic              rvc_en,
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic              cap_exec,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W:0]   cap_top,
  input  logic [ADDR_W-1:0] rep_base,
  input  logic [ADDR_W:0]   rep_top,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic [ADDR_W-1:0] exc_addr
);

  localparam logic [1:0] K_JAL  = 2'd0;
  localparam logic [1:0] K_JALR = 2'd1;
  localparam logic [1:0] K_BR   = 2'd2;

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_ALIGN = 3'd1;
  localparam logic [2:0] C_TAG   = 3'd2;
  localparam logic [2:0] C_SEAL  = 3'd3;
  localparam logic [2:0] C_PERM  = 3'd4;
  localparam logic [2:0] C_REP   = 3'd5;
  localparam logic [2:0] C_BND   = 3'd6;

  localparam logic [ADDR_W:0] SLACK_X = (ADDR_W+1)'(SLACK);

  logic            is_jalr, fires, misal, rep_bad, bnd_bad;
  logic [ADDR_W:0] tgt_x, end_x;
  logic [2:0]      cause_n;

  assign is_jalr = xfer_kind == K_JALR;
  assign fires   = xfer_valid &&
                   (xfer_kind == K_JAL || is_jalr || (xfer_kind == K_BR && taken));
  assign tgt_x   = {1'b0, target};
  assign end_x   = tgt_x + SLACK_X;
  assign misal   = target[0] | (~rvc_en & target[1]);
  assign rep_bad = (target < rep_base) || (tgt_x >= rep_top);
  assign bnd_bad = (target < cap_base) || (end_x > cap_top);

  always_comb begin
    cause_n = C_NONE;
    if (fires) begin
      if (misal)                   cause_n = C_ALIGN;
      else if (is_jalr && !cap_tag)  cause_n = C_TAG;
      else if (is_jalr && cap_sealed) cause_n = C_SEAL;
      else if (is_jalr && !cap_exec) cause_n = C_PERM;
      else if (rep_bad)            cause_n = C_REP;
      else if (bnd_bad)            cause_n = C_BND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= C_NONE;
      exc_addr  <= '0;
    end else begin
      exc_valid <= cause_n != C_NONE;
      exc_cause <= cause_n;
      if (xfer_valid) exc_addr <= target;
    end
  end

  p_valid_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid == (exc_cause != C_NONE));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> !exc_valid);

  p_addr_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> exc_addr == $past(target));

  p_not_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_kind == K_BR && !taken) |=> !exc_valid);

  p_odd_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && (xfer_kind == K_JAL || xfer_kind == K_JALR) && target[0])
      |=> exc_cause == C_ALIGN);

  p_no_cap_checks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_kind != K_JALR)
      |=> (exc_cause != C_TAG && exc_cause != C_SEAL && exc_cause != C_PERM));

  p_untagged_jalr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && is_jalr && !cap_tag && !target[0] && (rvc_en || !target[1]))
      |=> exc_cause == C_TAG);

endmodule

// File: tb/tb_xfer_target_check.sv
`timescale 1ns/1ps
module tb_xfer_target_check;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xfer_valid = 1'b0;
  logic [1:0]    xfer_kind = 2'd0;
  logic          taken = 1'b0;
  logic [AW-1:0] target = '0;
  logic          rvc_en = 1'b0;
  logic          cap_tag = 1'b1, cap_sealed = 1'b0, cap_exec = 1'b1;
  logic [AW-1:0] cap_base = 32'h1000;
  logic [AW:0]   cap_top  = 33'h2000;
  logic [AW-1:0] rep_base = 32'h0800;
  logic [AW:0]   rep_top  = 33'h2800;

  logic          v2, v4;
  logic [2:0]    c2, c4;
  logic [AW-1:0] a2, a4;

  always #4 clk = ~clk;

  xfer_target_check #(.ADDR_W(AW), .SLACK(2)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
    .taken(taken), .target(target), .rvc_en(rvc_en), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_exec(cap_exec), .cap_base(cap_base),
    .cap_top(cap_top), .rep_base(rep_base), .rep_top(rep_top),
    .exc_valid(v2), .exc_cause(c2), .exc_addr(a2));

  xfer_target_check #(.ADDR_W(AW), .SLACK(4)) dut4 (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
    .taken(taken), .target(target), .rvc_en(rvc_en), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_exec(cap_exec), .cap_base(cap_base),
    .cap_top(cap_top), .rep_base(rep_base), .rep_top(rep_top),
    .exc_valid(v4), .exc_cause(c4), .exc_addr(a4));

  typedef struct {
    logic          vld;
    logic [2:0]    e2;
    logic [2:0]    e4;
    logic [AW-1:0] addr;
    string         req;
  } item_t;

  item_t q[$];
  item_t cur;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  task automatic check(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      check(cur.req, "slack2 cause", c2, cur.e2);
      check(cur.req, "slack2 valid", v2, cur.e2 != 0);
      check(cur.req, "slack4 cause", c4, cur.e4);
      check(cur.req, "slack4 valid", v4, cur.e4 != 0);
      if (cur.vld) begin
        check(cur.req, "slack2 addr", a2, cur.addr);
        check(cur.req, "slack4 addr", a4, cur.addr);
      end
    end
  end

  task automatic drive(input logic [1:0] k, input logic tk, input logic [AW-1:0] t,
                       input logic rvc, input logic tg, input logic sl, input logic ex,
                       input logic [2:0] e2, input logic [2:0] e4, input string req);
    item_t it;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_kind = k; taken = tk; target = t; rvc_en = rvc;
    cap_tag = tg; cap_sealed = sl; cap_exec = ex;
    it.vld = 1'b1; it.e2 = e2; it.e4 = e4; it.addr = t; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input logic [1:0] k, input logic [AW-1:0] t, input string req);
    item_t it;
    @(negedge clk);
    xfer_valid = 1'b0; xfer_kind = k; taken = 1'b1; target = t;
    cap_tag = 1'b0; cap_sealed = 1'b1; cap_exec = 1'b0;
    it.vld = 1'b0; it.e2 = 3'd0; it.e4 = 3'd0; it.addr = '0; it.req = req;
    q.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset valid", v2, 0);
    check("R10", "reset cause", c2, 0);
    check("R10", "reset addr", a2, 0);
    rst_n = 1'b1;

    drive(2'd0, 0, 32'h1100, 0, 1, 0, 1, 3'd0, 3'd0, "R8");
    drive(2'd2, 0, 32'h1101, 0, 1, 0, 1, 3'd0, 3'd0, "R1");
    drive(2'd2, 0, 32'h3001, 0, 0, 1, 0, 3'd0, 3'd0, "R1");
    drive(2'd2, 1, 32'h1102, 0, 1, 0, 1, 3'd1, 3'd1, "R2");
    drive(2'd2, 1, 32'h1102, 1, 1, 0, 1, 3'd0, 3'd0, "R2");
    drive(2'd1, 1, 32'h1101, 1, 1, 0, 1, 3'd1, 3'd1, "R2");
    idle(2'd1, 32'h1101, "R10");
    drive(2'd1, 0, 32'h1100, 0, 0, 0, 1, 3'd2, 3'd2, "R3");
    drive(2'd1, 0, 32'h1100, 0, 1, 1, 1, 3'd3, 3'd3, "R4");
    drive(2'd1, 0, 32'h1100, 0, 1, 0, 0, 3'd4, 3'd4, "R5");
    drive(2'd0, 0, 32'h1100, 0, 0, 1, 0, 3'd0, 3'd0, "R6");
    drive(2'd2, 1, 32'h1104, 0, 0, 1, 0, 3'd0, 3'd0, "R6");
    drive(2'd0, 0, 32'h2900, 0, 1, 0, 1, 3'd5, 3'd5, "R7");
    drive(2'd2, 1, 32'h0700, 0, 1, 0, 1, 3'd5, 3'd5, "R7");
    drive(2'd0, 0, 32'h1FFE, 1, 1, 0, 1, 3'd0, 3'd6, "R8");
    drive(2'd0, 0, 32'h1FFC, 0, 1, 0, 1, 3'd0, 3'd0, "R8");
    drive(2'd0, 0, 32'h2000, 0, 1, 0, 1, 3'd6, 3'd6, "R8");
    drive(2'd2, 1, 32'h0FFE, 1, 1, 0, 1, 3'd6, 3'd6, "R8");
    drive(2'd1, 0, 32'h2902, 0, 0, 1, 0, 3'd1, 3'd1, "R9");
    drive(2'd1, 0, 32'h2900, 0, 0, 1, 0, 3'd2, 3'd2, "R9");
    drive(2'd1, 0, 32'h2900, 0, 1, 1, 0, 3'd3, 3'd3, "R9");
    drive(2'd1, 0, 32'h2900, 0, 1, 0, 0, 3'd4, 3'd4, "R9");
    drive(2'd1, 0, 32'h2900, 0, 1, 0, 1, 3'd5, 3'd5, "R9");
    drive(2'd3, 1, 32'h0001, 0, 0, 1, 0, 3'd0, 3'd0, "R10");
    idle(2'd0, 32'h0003, "R10");
    idle(2'd0, 32'h0000, "R10");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule